// File: doc/BRIEF.md
# I2C Register Write Sequencer

This block is a write-only I2C target that converts bus transactions into register-write strobes for a bank of configuration and coefficient registers. It oversamples SCL and SDA on the system clock and detects START and STOP conditions. It checks the 7-bit device address together with a write direction bit. For every byte addressed to it, the block acknowledges by pulling the open-drain SDA line low during the ninth clock.

After the device address, the next byte is a pointer byte. Its top bit requests auto-increment, and its low seven bits give the register address. Data then follows in one of two units:
- plain bytes, or
- 32-bit coefficient words sent as four bytes, most significant byte first.

An internal mode register at address 0x7E chooses the unit and a one-hot channel mask. Without auto-increment, the host may chain further pointer/data pairs before STOP. With auto-increment, the pointer advances after each unit and steps over a fixed set of reserved addresses.

Each completed unit produces a single-cycle strobe carrying the address, the data, a word flag and the channel mask. A consumer such as a coefficient memory or a register file uses that strobe.

Top module: `i2cRegWriteSeq`

## Requirements
- R1: While reset is held and right after it, SDA is not pulled low, no write strobe is issued, and the mode register is 0x00 (byte unit).
- R2: A first byte whose upper seven bits equal the device address (0x2A) and whose bit 0 is 0 is acknowledged, and so is every later byte of that transaction. A different address, or bit 0 set, receives no acknowledge, and all bytes up to the next START are ignored.
- R3: In the pointer byte, bit 7 is the auto-increment flag and bits 6:0 are the register address. With the flag clear, one data unit goes to that address, and the next byte before STOP is again a pointer byte.
- R4: With the flag set, successive data units go to successive addresses, starting at the given one, until STOP or START.
- R5: An auto-increment step never lands on 0x3B..0x49, 0x4F or 0x5E; it jumps to the next address after them. Stepping from 0x7F wraps to 0x00.
- R6: A data unit for address 0x7E is always a single byte. It loads the mode register and issues no write strobe, in either mode.
- R7: When mode bits 2:0 are nonzero, addresses 0x00..0x6B take four bytes, most significant first. One strobe follows the fourth byte, with the word flag set and the channel mask equal to mode bits 2:0. Addresses above 0x6B still take one byte.
- R8: A byte write has the byte in data bits 7:0, zeros above, the word flag clear and a zero channel mask.
- R9: A STOP or a repeated START in the middle of a word discards the bytes already received, with no strobe. The following transaction starts a fresh word.
- R10: Each write strobe lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | I2C clock line as seen on the pad |
| sdaIn | input | 1 | I2C data line as seen on the pad |
| sdaPullLow | output | 1 | 1 = drive SDA pad low (open drain), 0 = release |
| wrValid | output | 1 | Single-cycle register write strobe |
| wrAddr | output | 7 | Register address of the write |
| wrData | output | DATA_W | Write data, byte in bits 7:0 or full word |
| wrWord | output | 1 | 1 = 32-bit word write, 0 = byte write |
| wrChanMask | output | CHAN_N | One-hot channel select for word writes |

## Verification
Two things land in the same clock when auto-increment runs through address 0x7E: the mode register load and the pointer step. The width of the very next unit depends on the new mode value, not the old one. The bench provokes this with a transaction that starts with auto-increment at 0x7E and enables word mode there. It then sends one byte, which must be a byte write at 0x7F, and after the wrap four more bytes, which must form a single word write at 0x00 with channel mask 1. A design that read the mode one cycle late, or stepped the pointer wrongly at the wrap, produces a different strobe log.

// File: rtl/i2cWrPkg.sv
package i2cWrPkg;
  // Byte-level events handed from bus control to the datapath.
  typedef struct packed {
    logic frameReset;  // START or STOP seen: restart parsing
    logic subByte;     // a pointer byte is in rxByte
    logic dataByte;    // a data byte is in rxByte
  } ctlStrobeT;
endpackage

// File: rtl/i2cWrCtrl.sv
module i2cWrCtrl
  import i2cWrPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       expectSub,
  output ctlStrobeT  strobe,
  output logic [7:0] rxByte,
  output logic       sdaPullLow
);
  typedef enum logic [1:0] {ST_IDLE, ST_DEV, ST_BODY, ST_SKIP} busStateT;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic startEv, stopEv, sclRise, sclFall;
  busStateT state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
    end
  end

  assign sclS    = sclSync[SYNC_STAGES-1];
  assign sdaS    = sdaSync[SYNC_STAGES-1];
  assign startEv = sclS && sclD && sdaD && !sdaS;
  assign stopEv  = sclS && sclD && !sdaD && sdaS;
  assign sclRise = sclS && !sclD;
  assign sclFall = !sclS && sclD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD       <= 1'b1;
      sdaD       <= 1'b1;
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      rxByte     <= '0;
      sdaPullLow <= 1'b0;
      strobe     <= '0;
    end else begin
      sclD   <= sclS;
      sdaD   <= sdaS;
      strobe <= '0;
      if (startEv) begin
        state             <= ST_DEV;
        bitCnt            <= '0;
        sdaPullLow        <= 1'b0;
        strobe.frameReset <= 1'b1;
      end else if (stopEv) begin
        state             <= ST_IDLE;
        bitCnt            <= '0;
        sdaPullLow        <= 1'b0;
        strobe.frameReset <= 1'b1;
      end else if (state == ST_DEV || state == ST_BODY) begin
        if (sclRise && bitCnt < 4'd9) begin
          if (bitCnt < 4'd8) shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            rxByte <= shiftReg;
            if (state == ST_DEV) begin
              if (shiftReg[7:1] == DEV_ADDR && !shiftReg[0]) begin
                sdaPullLow <= 1'b1;
                state      <= ST_BODY;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              sdaPullLow <= 1'b1;
              if (expectSub) strobe.subByte  <= 1'b1;
              else           strobe.dataByte <= 1'b1;
            end
          end else if (bitCnt == 4'd9) begin
            sdaPullLow <= 1'b0;
            bitCnt     <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cWrDatapath.sv
module i2cWrDatapath
  import i2cWrPkg::*;
#(
  parameter int               ADDR_W   = 7,
  parameter int               DATA_W   = 32,
  parameter int               CHAN_N   = 3,
  parameter logic [ADDR_W-1:0] MODE_SUB = 7'h7E,
  parameter logic [ADDR_W-1:0] WORD_TOP = 7'h6B,
  parameter logic [ADDR_W-1:0] SKIP_LO  = 7'h3B,
  parameter logic [ADDR_W-1:0] SKIP_HI  = 7'h49,
  parameter logic [ADDR_W-1:0] SKIP_A   = 7'h4F,
  parameter logic [ADDR_W-1:0] SKIP_B   = 7'h5E
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [7:0]        rxByte,
  output logic              expectSub,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrWord,
  output logic [CHAN_N-1:0] wrChanMask
);
  localparam int BPW   = DATA_W / 8;
  localparam int IDX_W = $clog2(BPW);

  logic [7:0]        modeReg;
  logic              autoInc;
  logic [ADDR_W-1:0] ptr;
  logic [IDX_W-1:0]  byteIdx;
  logic [DATA_W-9:0] acc;
  logic [CHAN_N-1:0] chanSel;
  logic              wordUnit;

  assign chanSel  = modeReg[CHAN_N-1:0];
  assign wordUnit = (chanSel != '0) && (ptr <= WORD_TOP);

  function automatic logic [ADDR_W-1:0] stepPtr(input logic [ADDR_W-1:0] p);
    logic [ADDR_W-1:0] n;
    n = p + 1'b1;
    if (n >= SKIP_LO && n <= SKIP_HI) n = ADDR_W'(SKIP_HI + 1'b1);
    if (n == SKIP_A) n = ADDR_W'(SKIP_A + 1'b1);
    if (n == SKIP_B) n = ADDR_W'(SKIP_B + 1'b1);
    return n;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg    <= '0;
      autoInc    <= 1'b0;
      ptr        <= '0;
      byteIdx    <= '0;
      acc        <= '0;
      expectSub  <= 1'b1;
      wrValid    <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
      wrWord     <= 1'b0;
      wrChanMask <= '0;
    end else begin
      wrValid <= 1'b0;
      if (strobe.frameReset) begin
        expectSub <= 1'b1;
        byteIdx   <= '0;
      end else if (strobe.subByte) begin
        autoInc   <= rxByte[7];
        ptr       <= rxByte[ADDR_W-1:0];
        expectSub <= 1'b0;
        byteIdx   <= '0;
      end else if (strobe.dataByte) begin
        if (wordUnit && byteIdx != IDX_W'(BPW - 1)) begin
          acc     <= {acc[DATA_W-17:0], rxByte};
          byteIdx <= byteIdx + 1'b1;
        end else begin
          if (ptr == MODE_SUB) begin
            modeReg <= rxByte;
          end else begin
            wrValid    <= 1'b1;
            wrAddr     <= ptr;
            wrWord     <= wordUnit;
            wrChanMask <= wordUnit ? chanSel : '0;
            wrData     <= wordUnit ? {acc, rxByte} : DATA_W'(rxByte);
          end
          byteIdx <= '0;
          if (autoInc) ptr       <= stepPtr(ptr);
          else         expectSub <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2cRegWriteSeq.sv
module i2cRegWriteSeq
  import i2cWrPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         DATA_W      = 32,
  parameter int         CHAN_N      = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic              wrValid,
  output logic [6:0]        wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrWord,
  output logic [CHAN_N-1:0] wrChanMask
);
  localparam int ADDR_W = 7;

  ctlStrobeT  strobe;
  logic [7:0] rxByte;
  logic       expectSub;

  i2cWrCtrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .expectSub(expectSub), .strobe(strobe), .rxByte(rxByte),
    .sdaPullLow(sdaPullLow)
  );

  i2cWrDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_N(CHAN_N)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .expectSub(expectSub), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrWord(wrWord), .wrChanMask(wrChanMask)
  );
endmodule

// File: rtl/i2cWrChecker.sv
module i2cWrChecker #(
  parameter int DATA_W = 32,
  parameter int CHAN_N = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic              wrValid,
  input logic [6:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrWord,
  input logic [CHAN_N-1:0] wrChanMask
);
  always @(posedge clk) begin
    if (!rstN) a_r1_quiet_in_reset: assert (!sdaPullLow && !wrValid);
  end

  // R2: the acknowledge is only ever applied while SCL is low
  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  a_r6_no_mode_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> wrAddr != 7'h7E);

  a_r7_word_range: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrWord) |-> wrAddr <= 7'h6B);

  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrWord) |-> wrChanMask != '0);

  a_r8_byte_shape: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrWord) |-> (wrData[DATA_W-1:8] == '0 && wrChanMask == '0));

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);
endmodule

bind i2cRegWriteSeq i2cWrChecker #(.DATA_W(DATA_W), .CHAN_N(CHAN_N)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrWord(wrWord),
  .wrChanMask(wrChanMask)
);

// File: tb/tb_i2cRegWriteSeq.sv
`timescale 1ns/1ps
module tb_i2cRegWriteSeq;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPullLow, wrValid, wrWord;
  logic [6:0] wrAddr;
  logic [31:0] wrData;
  logic [2:0] wrChanMask;
  logic sdaBus;

  int vecCnt = 0, failCnt = 0;
  bit done = 0;

  logic [6:0]  logAddr [0:63];
  logic [31:0] logData [0:63];
  logic        logWord [0:63];
  logic [2:0]  logMask [0:63];
  int logCnt = 0;

  logic [7:0] txBuf [0:15];

  always #10 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  i2cRegWriteSeq dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrWord(wrWord), .wrChanMask(wrChanMask)
  );

  always @(negedge clk) begin
    if (wrValid && logCnt < 64) begin
      logAddr[logCnt] = wrAddr;
      logData[logCnt] = wrData;
      logWord[logCnt] = wrWord;
      logMask[logCnt] = wrChanMask;
      logCnt = logCnt + 1;
    end
  end

  task automatic checkEq(input string req, input string what, input longint act, input longint exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expectWrite(input string req, input int idx, input logic [6:0] a,
                             input logic [31:0] d, input logic w, input logic [2:0] m);
    checkEq(req, "addr", longint'(logAddr[idx]), longint'(a));
    checkEq(req, "data", longint'(logData[idx]), longint'(d));
    checkEq(req, "word", longint'(logWord[idx]), longint'(w));
    checkEq(req, "mask", longint'(logMask[idx]), longint'(m));
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclM = 1'b1; waitQ(); waitQ();
      sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    acked = !sdaBus;
    waitQ();
    sclM = 1'b0; waitQ();
  endtask

  // START, n bytes from txBuf, optional STOP; returns number of acked bytes
  task automatic runTxn(input int n, input bit withStop, output int acks);
    bit a;
    acks = 0;
    busStart();
    for (int i = 0; i < n; i++) begin
      sendByte(txBuf[i], a);
      if (a) acks++;
    end
    if (withStop) busStop();
  endtask

  task automatic setMode(input logic [7:0] v);
    int k;
    txBuf[0] = 8'h54; txBuf[1] = 8'h7E; txBuf[2] = v;
    runTxn(3, 1, k);
  endtask

  task automatic tReset();
    checkEq("R1", "sdaPullLow", longint'(sdaPullLow), 0);
    checkEq("R1", "wrValid", longint'(wrValid), 0);
  endtask

  task automatic tSingle();
    int mark, acks;
    mark = logCnt;
    txBuf[0] = 8'h54; txBuf[1] = 8'h10; txBuf[2] = 8'hA5;
    runTxn(3, 1, acks);
    checkEq("R2", "acks", acks, 3);
    checkEq("R10", "count", logCnt - mark, 1);
    expectWrite("R1 R3 R8", mark, 7'h10, 32'h0000_00A5, 1'b0, 3'b000);
  endtask

  task automatic tForeign();
    int mark, acks;
    mark = logCnt;
    txBuf[0] = 8'h56; txBuf[1] = 8'h10; txBuf[2] = 8'h77;
    runTxn(3, 1, acks);
    checkEq("R2", "acks foreign", acks, 0);
    txBuf[0] = 8'h55;
    runTxn(3, 1, acks);
    checkEq("R2", "acks read", acks, 0);
    checkEq("R2", "count", logCnt - mark, 0);
  endtask

  task automatic tPairs();
    int mark, acks;
    mark = logCnt;
    txBuf[0] = 8'h54; txBuf[1] = 8'h05; txBuf[2] = 8'h11;
    txBuf[3] = 8'h20; txBuf[4] = 8'h22;
    runTxn(5, 1, acks);
    checkEq("R3", "count", logCnt - mark, 2);
    expectWrite("R3", mark, 7'h05, 32'h11, 1'b0, 3'b000);
    expectWrite("R3", mark + 1, 7'h20, 32'h22, 1'b0, 3'b000);
  endtask

  task automatic tAutoSkip();
    int mark, acks;
    mark = logCnt;
    txBuf[0] = 8'h54; txBuf[1] = 8'hBA; txBuf[2] = 8'h01; txBuf[3] = 8'h02; txBuf[4] = 8'h03;
    runTxn(5, 1, acks);
    checkEq("R4", "count", logCnt - mark, 3);
    expectWrite("R4", mark, 7'h3A, 32'h01, 1'b0, 3'b000);
    expectWrite("R5", mark + 1, 7'h4A, 32'h02, 1'b0, 3'b000);
    expectWrite("R4", mark + 2, 7'h4B, 32'h03, 1'b0, 3'b000);
    mark = logCnt;
    txBuf[1] = 8'hCE; txBuf[2] = 8'h04; txBuf[3] = 8'h05;
    runTxn(4, 1, acks);
    expectWrite("R5", mark + 1, 7'h50, 32'h05, 1'b0, 3'b000);
    mark = logCnt;
    txBuf[1] = 8'hDD; txBuf[2] = 8'h06; txBuf[3] = 8'h07;
    runTxn(4, 1, acks);
    expectWrite("R5", mark + 1, 7'h5F, 32'h07, 1'b0, 3'b000);
  endtask

  task automatic tWord();
    int mark, acks;
    mark = logCnt;
    setMode(8'h02);
    checkEq("R6", "mode write count", logCnt - mark, 0);
    txBuf[0] = 8'h54; txBuf[1] = 8'h10;
    txBuf[2] = 8'h11; txBuf[3] = 8'h22; txBuf[4] = 8'h33; txBuf[5] = 8'h44;
    runTxn(6, 1, acks);
    checkEq("R2", "word acks", acks, 6);
    checkEq("R7", "count", logCnt - mark, 1);
    expectWrite("R7", mark, 7'h10, 32'h1122_3344, 1'b1, 3'b010);
    mark = logCnt;
    txBuf[1] = 8'hCE;
    txBuf[6] = 8'hA1; txBuf[7] = 8'hB2; txBuf[8] = 8'hC3; txBuf[9] = 8'hD4;
    runTxn(10, 1, acks);
    checkEq("R7", "auto count", logCnt - mark, 2);
    expectWrite("R7", mark, 7'h4E, 32'h1122_3344, 1'b1, 3'b010);
    expectWrite("R5", mark + 1, 7'h50, 32'hA1B2_C3D4, 1'b1, 3'b010);
    mark = logCnt;
    txBuf[1] = 8'h70; txBuf[2] = 8'h9C;
    runTxn(3, 1, acks);
    expectWrite("R7", mark, 7'h70, 32'h9C, 1'b0, 3'b000);
  endtask

  task automatic tAbort();
    int mark, acks;
    mark = logCnt;
    txBuf[0] = 8'h54; txBuf[1] = 8'h10; txBuf[2] = 8'h11; txBuf[3] = 8'h22;
    runTxn(4, 1, acks);
    checkEq("R9", "stop discard", logCnt - mark, 0);
    txBuf[2] = 8'hAA; txBuf[3] = 8'hBB;
    runTxn(4, 0, acks);
    txBuf[2] = 8'h01; txBuf[3] = 8'h02; txBuf[4] = 8'h03; txBuf[5] = 8'h04;
    runTxn(6, 1, acks);
    checkEq("R9", "restart count", logCnt - mark, 1);
    expectWrite("R9", mark, 7'h10, 32'h0102_0304, 1'b1, 3'b010);
    setMode(8'h00);
    mark = logCnt;
    txBuf[1] = 8'h12; txBuf[2] = 8'h5A;
    runTxn(3, 1, acks);
    expectWrite("R6", mark, 7'h12, 32'h5A, 1'b0, 3'b000);
  endtask

  task automatic tModeWrap();
    int mark, acks;
    mark = logCnt;
    txBuf[0] = 8'h54; txBuf[1] = 8'hFE; txBuf[2] = 8'h01; txBuf[3] = 8'h55;
    txBuf[4] = 8'hDE; txBuf[5] = 8'hAD; txBuf[6] = 8'hBE; txBuf[7] = 8'hEF;
    runTxn(8, 1, acks);
    checkEq("R6", "wrap count", logCnt - mark, 2);
    expectWrite("R6", mark, 7'h7F, 32'h55, 1'b0, 3'b000);
    expectWrite("R5", mark + 1, 7'h00, 32'hDEAD_BEEF, 1'b1, 3'b001);
    setMode(8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tSingle();
    tForeign();
    tPairs();
    tAutoSkip();
    tWord();
    tAbort();
    tModeWrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end
endmodule